// File: doc/BRIEF.md
# Stereo Attenuator and Output Router

This block is the volume and routing stage of a stereo audio path. Each incoming pair of signed samples arrives with a one-cycle strobe. Each channel is scaled by its own 8-bit gain code, with a linear gain of code/256. The code 00h silences the channel and FFh passes it unchanged. A soft-mute input does not cut the signal at once. Instead it walks both channel gains down by one step per sample until they reach zero. Releasing soft mute walks them back up to the programmed codes.

After scaling, a 4-bit routing code chooses what each output carries: silence, the scaled right channel, the scaled left channel, or the mono average of the two. Each routed pair leaves two clock cycles after its input strobe, with its own valid strobe. Gain codes, soft mute and the routing code are all sampled only on the input strobe. A sample therefore never sees a half-updated setting.

A shared ramp controller has four states:
- `ST_TRACK`: gains follow the codes directly.
- `ST_FALL`: gains are stepping down.
- `ST_SILENT`: both gains are zero.
- `ST_RISE`: gains are stepping up.

Transitions happen only on a strobe:
- Any state goes to `ST_FALL` on a strobe with soft mute set. It goes to `ST_SILENT` instead when that step leaves both gains at zero.
- `ST_TRACK` stays in `ST_TRACK` on a strobe with soft mute clear.
- `ST_FALL`, `ST_SILENT` and `ST_RISE` go to `ST_RISE` on a strobe with soft mute clear. They go to `ST_TRACK` instead when that step brings both gains onto their codes.

Top module: `stereo_vol_router`

## Requirements
- R1: A gain code of 00h makes the scaled channel exactly zero, and a code of FFh makes the scaled channel equal to the input sample.
- R2: For codes 01h to FEh the scaled channel equals floor(sample × code / 256), rounded toward minus infinity.
- R3: The left and right gain codes act independently; each scales only its own channel.
- R4: route_code[3:2] selects out_left and route_code[1:0] selects out_right, each with 00 = zero, 01 = scaled right, 10 = scaled left, 11 = floor((scaled left + scaled right) / 2). So 1001 is normal stereo, 0110 swapped stereo, 1111 mono on both outputs and 0000 silence.
- R5: The mono average is exact and never wraps, even when both scaled channels sit at the most positive or most negative sample value.
- R6: out_valid pulses for one cycle exactly two clock cycles after each in_valid pulse. The outputs carry that sample's result and hold their value until the next pulse.
- R7: Gain codes are taken only on the cycle in_valid is high. Changing atten_left or atten_right at any other time does not affect the sample already accepted.
- R8: While soft_mute is high on a strobe, each channel's applied gain is one less than the gain applied to the previous sample, stopping at zero.
- R9: While soft_mute is low on a strobe after a ramp, each gain moves one step toward its code, or is set to the code if it is above it. Once both gains equal their codes, the applied gain follows the code directly from the next strobe.
- R10: After reset out_valid is low, both outputs are zero and the controller is in `ST_TRACK`, so the first sample uses the codes present at its strobe.
- R11: The routing code and soft mute are taken only on the cycle in_valid is high. Changes between strobes do not affect the result already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle strobe marking a new sample pair |
| in_left | input | SAMPLE_W | Signed left input sample |
| in_right | input | SAMPLE_W | Signed right input sample |
| atten_left | input | CODE_W | Left gain code (00h silent, FFh unity) |
| atten_right | input | CODE_W | Right gain code (00h silent, FFh unity) |
| soft_mute | input | 1 | Request a ramped mute |
| route_code | input | 4 | Output routing, [3:2] for left output, [1:0] for right output |
| out_valid | output | 1 | One-cycle strobe marking a result pair |
| out_left | output | SAMPLE_W | Signed left output sample |
| out_right | output | SAMPLE_W | Signed right output sample |

## Verification
The hardest situation to reach from the ports is soft mute toggling part-way through a ramp while the two channels have different codes. In that case one gain has already reached its end point and the other is still stepping. The bench programs codes 200 and 90 and holds soft mute for a full fall. It then flips the mute several times at short, uneven intervals. It also changes the codes during a rise so that one gain ends above its new code. Every sample of these runs is compared against a gain model kept in the bench.

// File: rtl/svr_pkg.sv
package svr_pkg;

    localparam int NUM_CH  = 2;
    localparam int CH_LEFT = 0;
    localparam int CH_RGHT = 1;
    localparam int SEL_W   = 2;
    localparam int ROUTE_W = NUM_CH * SEL_W;

    typedef enum logic [1:0] {
        ST_TRACK  = 2'd0,
        ST_FALL   = 2'd1,
        ST_SILENT = 2'd2,
        ST_RISE   = 2'd3
    } ramp_state_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_MUTE  = 2'b00,
        SEL_RIGHT = 2'b01,
        SEL_LEFT  = 2'b10,
        SEL_MONO  = 2'b11
    } route_sel_t;

endpackage

// File: rtl/svr_gain_ctrl.sv
module svr_gain_ctrl
    import svr_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sample_stb,
    input  logic                              soft_mute,
    input  logic [NUM_CH-1:0][CODE_W-1:0]     code_i,
    output logic [NUM_CH-1:0][CODE_W-1:0]     gain_o,
    output ramp_state_t                       state_o
);

    ramp_state_t                      state_q, state_d;
    logic [NUM_CH-1:0][CODE_W-1:0]    gain_q, gain_d;
    logic [NUM_CH-1:0][CODE_W-1:0]    step_dn, step_up;
    logic [NUM_CH-1:0]                dn_zero, up_done;

    // Per-channel step candidates.
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_step
            assign step_dn[c] = (gain_q[c] == '0) ? '0 : gain_q[c] - 1'b1;
            assign step_up[c] = (gain_q[c] < code_i[c]) ? gain_q[c] + 1'b1
                                                         : code_i[c];
            assign dn_zero[c] = (step_dn[c] == '0);
            assign up_done[c] = (step_up[c] == code_i[c]);
        end
    endgenerate

    // Next-state and next-gain logic, evaluated on each strobe.
    always_comb begin
        state_d = state_q;
        gain_d  = gain_q;
        if (sample_stb) begin
            if (soft_mute) begin
                gain_d  = step_dn;
                state_d = (&dn_zero) ? ST_SILENT : ST_FALL;
            end else begin
                unique case (state_q)
                    ST_TRACK: begin
                        gain_d  = code_i;
                        state_d = ST_TRACK;
                    end
                    ST_FALL, ST_SILENT, ST_RISE: begin
                        gain_d  = step_up;
                        state_d = (&up_done) ? ST_TRACK : ST_RISE;
                    end
                endcase
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_TRACK;
        end else begin
            state_q <= state_d;
        end
    end

    // Output (gain) register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= '0;
        end else begin
            gain_q <= gain_d;
        end
    end

    assign gain_o  = gain_q;
    assign state_o = state_q;

endmodule

// File: rtl/svr_scaler.sv
module svr_scaler #(
    parameter int SAMPLE_W = 16,
    parameter int CODE_W   = 8
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [CODE_W-1:0]   gain_i,
    output logic [SAMPLE_W-1:0] scaled_o
);

    localparam int PROD_W = SAMPLE_W + CODE_W + 1;

    logic signed [PROD_W-1:0] samp_ext;
    logic signed [PROD_W-1:0] gain_ext;
    logic signed [PROD_W-1:0] product;

    assign samp_ext = {{(CODE_W + 1){sample_i[SAMPLE_W-1]}}, sample_i};
    assign gain_ext = {{(SAMPLE_W + 1){1'b0}}, gain_i};
    assign product  = samp_ext * gain_ext;

    // Full-scale code is exact unity; other codes take code/2^CODE_W, floored.
    always_comb begin
        if (gain_i == '1) begin
            scaled_o = sample_i;
        end else begin
            scaled_o = product[SAMPLE_W+CODE_W-1:CODE_W];
        end
    end

endmodule

// File: rtl/svr_router.sv
module svr_router
    import svr_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic [SAMPLE_W-1:0]               left_i,
    input  logic [SAMPLE_W-1:0]               right_i,
    input  logic [ROUTE_W-1:0]                route_i,
    output logic [NUM_CH-1:0][SAMPLE_W-1:0]   mix_o
);

    localparam int SUM_W = SAMPLE_W + 1;

    logic signed [SUM_W-1:0]  sum_wide;
    logic [SAMPLE_W-1:0]      mono;

    assign sum_wide = $signed({left_i[SAMPLE_W-1], left_i})
                    + $signed({right_i[SAMPLE_W-1], right_i});
    assign mono     = sum_wide[SUM_W-1:1];

    // Output 0 (left) uses the upper select field, output 1 the lower.
    generate
        for (genvar o = 0; o < NUM_CH; o++) begin : g_out
            route_sel_t sel;
            assign sel = route_sel_t'(route_i[(NUM_CH-1-o)*SEL_W +: SEL_W]);
            always_comb begin
                unique case (sel)
                    SEL_MUTE:  mix_o[o] = '0;
                    SEL_RIGHT: mix_o[o] = right_i;
                    SEL_LEFT:  mix_o[o] = left_i;
                    SEL_MONO:  mix_o[o] = mono;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/stereo_vol_router.sv
module stereo_vol_router
    import svr_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int CODE_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [SAMPLE_W-1:0]  in_left,
    input  logic [SAMPLE_W-1:0]  in_right,
    input  logic [CODE_W-1:0]    atten_left,
    input  logic [CODE_W-1:0]    atten_right,
    input  logic                 soft_mute,
    input  logic [ROUTE_W-1:0]   route_code,
    output logic                 out_valid,
    output logic [SAMPLE_W-1:0]  out_left,
    output logic [SAMPLE_W-1:0]  out_right
);

    logic [NUM_CH-1:0][CODE_W-1:0]    codes;
    logic [NUM_CH-1:0][CODE_W-1:0]    gains;
    logic [NUM_CH-1:0][SAMPLE_W-1:0]  samp_q;
    logic [NUM_CH-1:0][SAMPLE_W-1:0]  scaled;
    logic [NUM_CH-1:0][SAMPLE_W-1:0]  mixed;
    logic [ROUTE_W-1:0]               route_q;
    logic                             valid_a;
    ramp_state_t                      ctrl_state;
    logic [CODE_W-1:0]                gain_left, gain_right;

    assign codes[CH_LEFT] = atten_left;
    assign codes[CH_RGHT] = atten_right;
    assign gain_left      = gains[CH_LEFT];
    assign gain_right     = gains[CH_RGHT];

    svr_gain_ctrl #(
        .CODE_W (CODE_W)
    ) u_gain (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (in_valid),
        .soft_mute  (soft_mute),
        .code_i     (codes),
        .gain_o     (gains),
        .state_o    (ctrl_state)
    );

    // Stage A: capture the sample pair and routing alongside the gains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q  <= '0;
            route_q <= '0;
            valid_a <= 1'b0;
        end else begin
            valid_a <= in_valid;
            if (in_valid) begin
                samp_q[CH_LEFT] <= in_left;
                samp_q[CH_RGHT] <= in_right;
                route_q         <= route_code;
            end
        end
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_scale
            svr_scaler #(
                .SAMPLE_W (SAMPLE_W),
                .CODE_W   (CODE_W)
            ) u_scale (
                .sample_i (samp_q[c]),
                .gain_i   (gains[c]),
                .scaled_o (scaled[c])
            );
        end
    endgenerate

    svr_router #(
        .SAMPLE_W (SAMPLE_W)
    ) u_route (
        .left_i  (scaled[CH_LEFT]),
        .right_i (scaled[CH_RGHT]),
        .route_i (route_q),
        .mix_o   (mixed)
    );

    // Stage B: output registers, loaded only with a valid result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= valid_a;
            if (valid_a) begin
                out_left  <= mixed[CH_LEFT];
                out_right <= mixed[CH_RGHT];
            end
        end
    end

endmodule

// File: rtl/svr_checker.sv
module svr_checker
    import svr_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int CODE_W   = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 soft_mute,
    input logic [CODE_W-1:0]    atten_left,
    input logic [CODE_W-1:0]    gain_left,
    input logic [CODE_W-1:0]    gain_right,
    input ramp_state_t          ctrl_state,
    input logic                 valid_a,
    input logic [ROUTE_W-1:0]   route_q,
    input logic                 out_valid,
    input logic [SAMPLE_W-1:0]  out_left
);

    // R6
    out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_a |=> $stable(out_left));

    // R7
    gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(gain_left) && $stable(gain_right)));

    // R7
    track_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !soft_mute && ctrl_state == ST_TRACK)
        |=> gain_left == $past(atten_left));

    // R8
    fall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && soft_mute)
        |=> (gain_left == '0 || gain_left == CODE_W'($past(gain_left) - 1'b1)));

    // R8
    silent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_state == ST_SILENT |-> (gain_left == '0 && gain_right == '0));

    // R9
    rise_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !soft_mute && ctrl_state != ST_TRACK)
        |=> (gain_left == $past(atten_left)
             || gain_left == CODE_W'($past(gain_left) + 1'b1)));

    // R4
    mute_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_a && route_q[ROUTE_W-1 -: SEL_W] == SEL_MUTE) |=> out_left == '0);

endmodule

bind stereo_vol_router svr_checker #(
    .SAMPLE_W (SAMPLE_W),
    .CODE_W   (CODE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .soft_mute  (soft_mute),
    .atten_left (atten_left),
    .gain_left  (gain_left),
    .gain_right (gain_right),
    .ctrl_state (ctrl_state),
    .valid_a    (valid_a),
    .route_q    (route_q),
    .out_valid  (out_valid),
    .out_left   (out_left)
);

// File: tb/stereo_vol_router_bench.sv
`timescale 1ns/1ps
module stereo_vol_router_bench;

    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_left = '0, in_right = '0;
    logic [7:0]    atten_left = '0, atten_right = '0;
    logic          soft_mute = 1'b0;
    logic [3:0]    route_code = 4'b1001;
    logic          out_valid;
    logic [W-1:0]  out_left, out_right;

    int  n_total = 0;
    int  n_fail  = 0;
    bit  finished = 0;

    // model state
    int  mg_l = 0, mg_r = 0;
    bit  m_track = 1;

    always #4 clk = ~clk;

    stereo_vol_router u_stereo_vol_router (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_left     (in_left),
        .in_right    (in_right),
        .atten_left  (atten_left),
        .atten_right (atten_right),
        .soft_mute   (soft_mute),
        .route_code  (route_code),
        .out_valid   (out_valid),
        .out_left    (out_left),
        .out_right   (out_right)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int scale(input int x, input int g);
        if (g == 255) return x;
        return (x * g) >>> 8;
    endfunction

    function automatic int pick(input logic [1:0] sel, input int l, input int r);
        case (sel)
            2'b00:   return 0;
            2'b01:   return r;
            2'b10:   return l;
            default: return (l + r) >>> 1;
        endcase
    endfunction

    function automatic int sx(input logic [W-1:0] v);
        return int'($signed(v));
    endfunction

    // Advance the bench gain model for one strobe.
    task automatic model_step();
        int cl, cr;
        cl = int'(atten_left);
        cr = int'(atten_right);
        if (soft_mute) begin
            if (mg_l > 0) mg_l--;
            if (mg_r > 0) mg_r--;
            m_track = 0;
        end else if (m_track) begin
            mg_l = cl;
            mg_r = cr;
        end else begin
            mg_l = (mg_l < cl) ? mg_l + 1 : cl;
            mg_r = (mg_r < cr) ? mg_r + 1 : cr;
            if (mg_l == cl && mg_r == cr) m_track = 1;
        end
    endtask

    // Send one pair, disturb the settings between strobes, check result and hold.
    task automatic send(input int l, input int r, input string tag);
        int el, er, sl, sr;
        logic [7:0] sv_al, sv_ar;
        logic [3:0] sv_rc;
        logic       sv_sm;
        model_step();
        sl = scale(l, mg_l);
        sr = scale(r, mg_r);
        el = pick(route_code[3:2], sl, sr);
        er = pick(route_code[1:0], sl, sr);
        in_left  = W'(l);
        in_right = W'(r);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        sv_al = atten_left; sv_ar = atten_right; sv_rc = route_code; sv_sm = soft_mute;
        // R7 R11: settings changed after the strobe must not reach this sample
        atten_left  = ~atten_left;
        atten_right = atten_right ^ 8'h5A;
        route_code  = ~route_code;
        soft_mute   = ~soft_mute;
        @(negedge clk);
        chk(out_valid == 1'b1, "R6 valid pulse", int'(out_valid), 1);
        chk(sx(out_left) == el, {tag, " left"}, sx(out_left), el);
        chk(sx(out_right) == er, {tag, " right"}, sx(out_right), er);
        atten_left = sv_al; atten_right = sv_ar; route_code = sv_rc; soft_mute = sv_sm;
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 single pulse", int'(out_valid), 0);
        chk(sx(out_left) == el, "R6 hold", sx(out_left), el);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(out_valid == 1'b0, "R10 reset valid", int'(out_valid), 0);
        chk(out_left == '0, "R10 reset left", sx(out_left), 0);
        chk(out_right == '0, "R10 reset right", sx(out_right), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3: every code, mirrored codes on the two channels
        for (int code = 0; code < 256; code++) begin
            atten_left  = 8'(code);
            atten_right = 8'(255 - code);
            send(32767, -32768, "R1 R2 R3 extremes");
            send(-12345, 23456, "R2 R3 mid");
            send(1, -1, "R2 small");
        end

        // R4 R5: all sixteen routing codes at several gains
        for (int rc = 0; rc < 16; rc++) begin
            route_code = 4'(rc);
            atten_left = 8'hFF; atten_right = 8'hFF;
            send(32767, 32767, "R4 R5 positive full scale");
            send(-32768, -32768, "R4 R5 negative full scale");
            send(-32768, 32767, "R4 R5 opposite");
            send(-7, 4, "R4 odd sum");
            atten_left = 8'd200; atten_right = 8'd100;
            send(1000, -3001, "R4 scaled");
        end

        // R8 R9: full fall and rise with unequal codes
        route_code  = 4'b1001;
        atten_left  = 8'd200;
        atten_right = 8'd90;
        send(20000, -20000, "R9 track entry");
        soft_mute = 1'b1;
        for (int i = 0; i < 205; i++) send(20000, -20000, "R8 fall");
        soft_mute = 1'b0;
        for (int i = 0; i < 205; i++) send(20000, -20000, "R9 rise");
        // R8 R9: toggling mid-ramp
        for (int k = 0; k < 6; k++) begin
            soft_mute = 1'b1;
            for (int i = 0; i < 7 + 5 * k; i++) send(-15000, 15000, "R8 toggle fall");
            soft_mute = 1'b0;
            for (int i = 0; i < 3 + 2 * k; i++) send(-15000, 15000, "R9 toggle rise");
        end
        // R9: code lowered during a rise, gain above it snaps to code
        atten_left  = 8'd40;
        atten_right = 8'd10;
        for (int i = 0; i < 60; i++) send(31000, -31000, "R9 lowered code");
        // R9: tracking again, code change applies at once
        atten_left = 8'd255;
        send(12345, -12345, "R9 track applies");

        finished = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule